// File: doc/BRIEF.md
# Staged Output Buffer with Trigger Transfer

This block keeps six bits of pin data staged ahead of time, so that the pins change at a hardware event and not when software writes. Two small buffer registers, a lower nibble and an upper two-bit field, sit behind a simple peripheral register bus. Each buffer has its own address. When a trigger pulse arrives, the buffered bits are copied into an output latch, and that latch drives the pins.

A mode input picks the layout. In split layout, the lower nibble is one 4-bit channel and the upper field is one 2-bit channel. Each channel is written through its own address and moved to the pins by its own trigger. In combined layout, the six bits form one channel. A byte write through either address loads the whole field, and the first trigger moves all six bits together. In both layouts, a read from either address returns the full staged byte. Single-bit writes, which give a bit index and a value, are supported in both layouts.

Top module: `staged_out_unit`

## Requirements
- R1: After reset both buffers and all six output pins are 0, and a read at either mapped address returns 0x00.
- R2: In split mode, a byte write to the lower address loads data[3:0] into the lower buffer and leaves the upper buffer unchanged.
- R3: In split mode, a byte write to the upper address loads data[5:4] into the upper buffer and leaves the lower buffer unchanged. Bits [7:6] are never stored and always read back as 0.
- R4: In combined mode, a byte write to either mapped address loads data[3:0] into the lower buffer and data[5:4] into the upper buffer in the same cycle.
- R5: A read at either mapped address returns {2'b00, upper, lower}. A read at any other address returns 0x00.
- R6: In split mode, a single-bit write changes only the indexed bit of the addressed buffer. At the lower address, index 0..3 is valid. At the upper address, index 0..1 selects pin bit 4 or 5. Any other index changes nothing.
- R7: In combined mode, a single-bit write through either address uses index 0..5 as a position in the 6-bit field. Index 6 or 7 changes nothing.
- R8: In split mode, a pulse on trigLo copies the lower buffer to pins [3:0] on the next clock edge, and a pulse on trigHi copies the upper buffer to pins [5:4]. Neither pulse touches the other channel's pins.
- R9: In combined mode, trigLo copies all six buffered bits to the pins, and trigHi has no effect.
- R10: When a write and a trigger occur in the same cycle, the pins take the buffer value from before the write, and the buffer takes the new data.
- R11: Without a trigger the pins hold their value, whatever bus writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeCombined | input | 1 | 0 = split layout (4-bit + 2-bit channels), 1 = combined 6-bit channel |
| busAddr | input | ADDR_W | Register address |
| busWrEn | input | 1 | Write strobe |
| busBitOp | input | 1 | 1 = single-bit write, 0 = byte write |
| busBitIdx | input | 3 | Bit index for a single-bit write |
| busBitVal | input | 1 | Bit value for a single-bit write |
| busWrData | input | 8 | Byte write data |
| busRdData | output | 8 | Read data, combinational from busAddr |
| trigLo | input | 1 | Transfer trigger: lower channel, or whole field in combined mode |
| trigHi | input | 1 | Transfer trigger for the upper channel in split mode |
| pinOut | output | 6 | Output latch driving the pins |

## Verification
The bench builds the block with its default parameters: a 4-bit address bus, the lower buffer at address 0 and the upper buffer at address 2. Because these addresses are sparse, random stimulus also reaches unmapped addresses 1, 3 and up, and the bench checks there that writes are dropped and reads return zero. The 3-bit index range covers every out-of-range bit position in both layouts, so ignored single-bit writes occur often. Random mode flips between writes and triggers exercise every crossing of layout and channel.

// File: rtl/staged_out_pkg.sv
package staged_out_pkg;
  localparam int LO_W   = 4;
  localparam int HI_W   = 2;
  localparam int OUT_W  = LO_W + HI_W;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 3;
  localparam int POS_W  = 4;

  typedef struct packed {
    logic              ldLoByte;
    logic              ldHiByte;
    logic              ldLoBit;
    logic              ldHiBit;
    logic [POS_W-1:0]  bitPos;
    logic              bitVal;
    logic [BYTE_W-1:0] wrData;
    logic              xferLo;
    logic              xferHi;
  } strobe_t;
endpackage

// File: rtl/staged_out_ctrl.sv
module staged_out_ctrl
  import staged_out_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 2
) (
  input  logic              modeCombined,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busBitOp,
  input  logic [IDX_W-1:0]  busBitIdx,
  input  logic              busBitVal,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic              trigLo,
  input  logic              trigHi,
  output strobe_t           strb,
  output logic              rdHit
);
  localparam logic [ADDR_W-1:0] LoAddr = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HiAddr = ADDR_W'(HI_ADDR);

  logic hitLo, hitHi, byteWr, bitWr, posOk;
  logic [POS_W-1:0] pos;

  assign hitLo  = (busAddr == LoAddr);
  assign hitHi  = (busAddr == HiAddr);
  assign rdHit  = hitLo | hitHi;
  assign byteWr = busWrEn & ~busBitOp & rdHit;
  assign bitWr  = busWrEn &  busBitOp & rdHit;

  // Map the bit index into the 6-bit field position space
  always_comb begin
    if (modeCombined) begin
      pos   = POS_W'(busBitIdx);
      posOk = (POS_W'(busBitIdx) < POS_W'(OUT_W));
    end else if (hitLo) begin
      pos   = POS_W'(busBitIdx);
      posOk = (POS_W'(busBitIdx) < POS_W'(LO_W));
    end else begin
      pos   = POS_W'(busBitIdx) + POS_W'(LO_W);
      posOk = (POS_W'(busBitIdx) < POS_W'(HI_W));
    end
  end

  always_comb begin
    strb          = '0;
    strb.wrData   = busWrData;
    strb.bitVal   = busBitVal;
    strb.bitPos   = pos;
    strb.ldLoByte = byteWr & (modeCombined | hitLo);
    strb.ldHiByte = byteWr & (modeCombined | hitHi);
    strb.ldLoBit  = bitWr & posOk & (pos < POS_W'(LO_W));
    strb.ldHiBit  = bitWr & posOk & (pos >= POS_W'(LO_W));
    strb.xferLo   = trigLo;
    strb.xferHi   = modeCombined ? trigLo : trigHi;
  end
endmodule

// File: rtl/staged_out_dp.sv
module staged_out_dp
  import staged_out_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic [BYTE_W-1:0] bufWord,
  output logic [OUT_W-1:0]  outQ
);
  logic [LO_W-1:0] bufLo;
  logic [HI_W-1:0] bufHi;

  for (genvar i = 0; i < LO_W; i++) begin : g_lo
    always_ff @(posedge clk) begin
      if (!rstN)                                             bufLo[i] <= 1'b0;
      else if (strb.ldLoByte)                                bufLo[i] <= strb.wrData[i];
      else if (strb.ldLoBit && strb.bitPos == POS_W'(i))     bufLo[i] <= strb.bitVal;
    end
    always_ff @(posedge clk) begin
      if (!rstN)            outQ[i] <= 1'b0;
      else if (strb.xferLo) outQ[i] <= bufLo[i];
    end
  end

  for (genvar j = 0; j < HI_W; j++) begin : g_hi
    always_ff @(posedge clk) begin
      if (!rstN)                                                bufHi[j] <= 1'b0;
      else if (strb.ldHiByte)                                   bufHi[j] <= strb.wrData[LO_W+j];
      else if (strb.ldHiBit && strb.bitPos == POS_W'(LO_W+j))   bufHi[j] <= strb.bitVal;
    end
    always_ff @(posedge clk) begin
      if (!rstN)            outQ[LO_W+j] <= 1'b0;
      else if (strb.xferHi) outQ[LO_W+j] <= bufHi[j];
    end
  end

  assign bufWord = BYTE_W'({bufHi, bufLo});

  // R8 / R10: transfer takes the pre-edge buffer contents
  p_lo_xfer_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferLo |=> outQ[LO_W-1:0] == $past(bufLo));
  p_hi_xfer_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferHi |=> outQ[OUT_W-1:LO_W] == $past(bufHi));
  // R11: pins are frozen without a transfer strobe
  p_pins_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.xferLo || strb.xferHi) |=> $stable(outQ));
  // R2: lower-only loads leave the upper buffer alone
  p_hi_untouched_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.ldHiByte || strb.ldHiBit) |=> $stable(bufHi));
endmodule

// File: rtl/staged_out_unit.sv
module staged_out_unit
  import staged_out_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeCombined,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busBitOp,
  input  logic [2:0]        busBitIdx,
  input  logic              busBitVal,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              trigLo,
  input  logic              trigHi,
  output logic [5:0]        pinOut
);
  strobe_t           strb;
  logic              rdHit;
  logic [BYTE_W-1:0] bufWord;

  staged_out_ctrl #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_ctrl (
    .modeCombined(modeCombined), .busAddr(busAddr), .busWrEn(busWrEn),
    .busBitOp(busBitOp), .busBitIdx(busBitIdx), .busBitVal(busBitVal),
    .busWrData(busWrData), .trigLo(trigLo), .trigHi(trigHi),
    .strb(strb), .rdHit(rdHit)
  );

  staged_out_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bufWord(bufWord), .outQ(pinOut)
  );

  assign busRdData = rdHit ? bufWord : '0;

  // R9: upper trigger alone is inert in combined layout
  p_hi_trig_inert_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeCombined && trigHi && !trigLo) |=> $stable(pinOut));
  // R3: the two unused read bits stay clear after any write
  p_top_bits_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |=> busRdData[7:6] == 2'b00);
endmodule

// File: tb/staged_out_unit_tb.sv
module staged_out_unit_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeCombined = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busBitOp = 1'b0;
  logic [2:0] busBitIdx = '0;
  logic       busBitVal = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       trigLo = 1'b0;
  logic       trigHi = 1'b0;
  logic [5:0] pinOut;

  int errors = 0;
  int checks = 0;
  logic [3:0] mLo = '0;
  logic [1:0] mHi = '0;
  logic [5:0] mOut = '0;

  always #2 clk = ~clk;

  staged_out_unit u_dut (
    .clk(clk), .rstN(rstN), .modeCombined(modeCombined), .busAddr(busAddr),
    .busWrEn(busWrEn), .busBitOp(busBitOp), .busBitIdx(busBitIdx),
    .busBitVal(busBitVal), .busWrData(busWrData), .busRdData(busRdData),
    .trigLo(trigLo), .trigHi(trigHi), .pinOut(pinOut)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [3:0] a);
    return (a == 4'd0 || a == 4'd2) ? {2'b00, mHi, mLo} : 8'h00;
  endfunction

  // Model from requirements: pins from old buffers, then buffers updated
  task automatic modelStep(input logic md, input logic [3:0] a, input logic wr,
                           input logic bop, input logic [2:0] idx, input logic bv,
                           input logic [7:0] d, input logic tl, input logic th);
    logic [5:0] buf6;
    logic hl, hh;
    int p;
    buf6 = {mHi, mLo};
    if (tl && md) mOut = buf6;
    else begin
      if (tl) mOut[3:0] = mLo;
      if (th && !md) mOut[5:4] = mHi;
    end
    hl = (a == 4'd0);
    hh = (a == 4'd2);
    if (wr && (hl || hh)) begin
      if (!bop) begin
        if (md || hl) mLo = d[3:0];
        if (md || hh) mHi = d[5:4];
      end else begin
        p = -1;
        if (md) begin if (idx < 6) p = idx; end
        else if (hl) begin if (idx < 4) p = idx; end
        else begin if (idx < 2) p = idx + 4; end
        if (p >= 0) begin
          buf6 = {mHi, mLo};
          buf6[p] = bv;
          mLo = buf6[3:0];
          mHi = buf6[5:4];
        end
      end
    end
  endtask

  task automatic step(input logic md, input logic [3:0] a, input logic wr,
                      input logic bop, input logic [2:0] idx, input logic bv,
                      input logic [7:0] d, input logic tl, input logic th);
    @(negedge clk);
    modeCombined = md; busAddr = a; busWrEn = wr; busBitOp = bop;
    busBitIdx = idx; busBitVal = bv; busWrData = d; trigLo = tl; trigHi = th;
    @(posedge clk);
    #1;
    busWrEn = 1'b0; trigLo = 1'b0; trigHi = 1'b0;
    modelStep(md, a, wr, bop, idx, bv, d, tl, th);
  endtask

  task automatic checkAll(input string pinTag, input string rdTag);
    check(pinOut == mOut, pinTag, pinOut, mOut);
    busAddr = 4'd0; #0.1;
    check(busRdData == expRead(4'd0), rdTag, busRdData, expRead(4'd0));
    busAddr = 4'd2; #0.1;
    check(busRdData == expRead(4'd2), rdTag, busRdData, expRead(4'd2));
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    checkAll("R1 pins", "R1 read");

    // R3: split upper write, top bits dropped
    step(0, 4'd2, 1, 0, 0, 0, 8'hF3, 0, 0);
    check(busRdData == 8'h30, "R3 upper write", busRdData, 8'h30);
    // R2: split lower write keeps upper
    step(0, 4'd0, 1, 0, 0, 0, 8'hFA, 0, 0);
    check(busRdData == 8'h3A, "R2 lower write", busRdData, 8'h3A);
    // R11: no trigger, pins unchanged
    check(pinOut == 6'h00, "R11 pins hold", pinOut, 0);
    // R8: split hi trigger only
    step(0, 4'd0, 0, 0, 0, 0, 8'h00, 0, 1);
    check(pinOut == 6'h30, "R8 hi trigger", pinOut, 6'h30);
    step(0, 4'd0, 0, 0, 0, 0, 8'h00, 1, 0);
    check(pinOut == 6'h3A, "R8 lo trigger", pinOut, 6'h3A);
    // R10: write and trigger together
    step(0, 4'd0, 1, 0, 0, 0, 8'h05, 1, 0);
    check(pinOut == 6'h3A, "R10 old value to pins", pinOut, 6'h3A);
    check(busRdData == 8'h35, "R10 new value in buffer", busRdData, 8'h35);
    // R4: combined write through upper address
    step(1, 4'd2, 1, 0, 0, 0, 8'h1C, 0, 0);
    check(busRdData == 8'h1C, "R4 combined write", busRdData, 8'h1C);
    // R9: trigHi inert in combined mode
    step(1, 4'd0, 0, 0, 0, 0, 8'h00, 0, 1);
    check(pinOut == 6'h3A, "R9 hi trigger ignored", pinOut, 6'h3A);
    step(1, 4'd0, 0, 0, 0, 0, 8'h00, 1, 0);
    check(pinOut == 6'h1C, "R9 combined transfer", pinOut, 6'h1C);
    // R7: combined bit write index 5 and ignored index 6
    step(1, 4'd0, 1, 1, 3'd5, 1, 8'h00, 0, 0);
    check(busRdData == 8'h3C, "R7 bit 5 set", busRdData, 8'h3C);
    step(1, 4'd0, 1, 1, 3'd6, 1, 8'h00, 0, 0);
    check(busRdData == 8'h3C, "R7 index 6 ignored", busRdData, 8'h3C);
    // R6: split upper-address index 2 ignored, index 0 hits bit 4
    step(0, 4'd2, 1, 1, 3'd2, 0, 8'h00, 0, 0);
    check(busRdData == 8'h3C, "R6 upper index 2 ignored", busRdData, 8'h3C);
    step(0, 4'd2, 1, 1, 3'd0, 0, 8'h00, 0, 0);
    check(busRdData == 8'h2C, "R6 upper index 0", busRdData, 8'h2C);
    // R5: unmapped address read and write
    step(0, 4'd1, 1, 0, 0, 0, 8'hFF, 0, 0);
    check(busRdData == 8'h00, "R5 unmapped read", busRdData, 0);
    checkAll("R11 pins", "R5 read");

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] a;
      int sel;
      sel = $urandom_range(0, 4);
      a = (sel < 2) ? 4'd0 : (sel < 4) ? 4'd2 : 4'($urandom_range(0, 15));
      step(1'($urandom), a, ($urandom_range(0, 3) != 0), 1'($urandom),
           3'($urandom), 1'($urandom), 8'($urandom),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
      checkAll("R8 random pins", "R5 random read");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule